// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder

This block adds two unsigned binary words and a carry-in within a single combinational path. It does not ripple a carry from bit to bit. Each bit first produces a generate and a propagate flag. A logarithmic-depth prefix network then merges neighbouring bit groups with one associative operator.

The network is recursive:

- A first row of operators merges adjacent bit pairs.
- A half-width copy of the same network resolves those pair groups.
- A last row of operators fills in the group terms for the even positions that the pair stage skipped.

The carry-in enters as an extra group below bit 0, with generate equal to the carry-in and propagate equal to 0. Each sum bit is the bit propagate XOR the carry that reaches that position.

The block also outputs the generate and propagate of the whole word. A wider adder can use them to build its carry chain from several of these blocks. The width is a parameter. It must be a power of two and at least 2; any other value stops elaboration.

Top module: `bk_prefix_adder`

## Requirements
- R1: `sum` equals (`opA` + `opB` + `carryIn`) modulo 2^WIDTH, for every input combination.
- R2: `carryOut` equals bit WIDTH of the full-precision sum `opA` + `opB` + `carryIn`.
- R3: `groupProp` is 1 exactly when every bit of `opA` XOR `opB` is 1; otherwise it is 0.
- R4: `groupGen` equals the carry out of `opA` + `opB` with the carry-in taken as 0, so it does not depend on `carryIn`.
- R5: `carryOut` equals `groupGen` OR (`groupProp` AND `carryIn`). The carry-in reaches `carryOut` only when the whole word propagates.
- R6: `groupGen` and `groupProp` are never 1 at the same time.
- R7: Behaviour holds at WIDTH = 32 as well as at the default WIDTH = 8. This includes a carry-in that travels through all bits: `opA` all ones, `opB` zero and `carryIn` 1 give a zero sum with `carryOut` 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the sum |
| carryOut | output | 1 | Carry out of the top bit |
| groupGen | output | 1 | Whole-word generate, independent of carry-in |
| groupProp | output | 1 | Whole-word propagate |

## Verification
The bound checker tests on every input change that sum and carry match a plain addition, that the whole-word propagate and generate follow their definitions, that the carry-out decomposes into those two terms, and that the two group flags exclude each other. The bench scenarios cover the rest. Every one of the 2^17 input combinations is applied at 8 bits, and random and directed words are applied to a 32-bit instance, including the carry-in that crosses the whole word. Only these scenarios show that the recursion is correct at a second depth.

// File: rtl/bk_adder_pkg.sv
package bk_adder_pkg;

  typedef struct packed {
    logic gen;
    logic prop;
  } gpPair_t;

  // Merge a higher group with the adjacent lower group.
  function automatic gpPair_t gpJoin(input gpPair_t hiGrp, input gpPair_t loGrp);
    gpPair_t res;
    res.gen  = hiGrp.gen | (hiGrp.prop & loGrp.gen);
    res.prop = hiGrp.prop & loGrp.prop;
    return res;
  endfunction

endpackage

// File: rtl/bk_pg_gen.sv
module bk_pg_gen
  import bk_adder_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic    [WIDTH-1:0] opA,
  input  logic    [WIDTH-1:0] opB,
  output gpPair_t [WIDTH-1:0] bitGp
);

  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    assign bitGp[i].gen  = opA[i] & opB[i];
    assign bitGp[i].prop = opA[i] ^ opB[i];
  end

endmodule

// File: rtl/bk_prefix_net.sv
module bk_prefix_net
  import bk_adder_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  gpPair_t [WIDTH-1:0] bitGp,
  output gpPair_t [WIDTH-1:0] prefixGp   // prefixGp[i] covers bits [0,i]
);

  localparam int HALF = WIDTH / 2;

  if (WIDTH == 2) begin : gLeaf
    always_comb begin
      prefixGp[0] = bitGp[0];
      prefixGp[1] = gpJoin(bitGp[1], bitGp[0]);
    end
  end else begin : gNode
    gpPair_t [HALF-1:0] pairGp;
    gpPair_t [HALF-1:0] pairPrefix;

    // Upward row: adjacent pairs
    always_comb begin
      for (int k = 0; k < HALF; k++) begin
        pairGp[k] = gpJoin(bitGp[2*k+1], bitGp[2*k]);
      end
    end

    bk_prefix_net #(.WIDTH(HALF)) uInner (
      .bitGp    (pairGp),
      .prefixGp (pairPrefix)
    );

    // Downward row: odd positions come straight from the inner net,
    // even positions above 0 take one more operator.
    always_comb begin
      prefixGp[0] = bitGp[0];
      for (int k = 0; k < HALF; k++) begin
        prefixGp[2*k+1] = pairPrefix[k];
        if (k > 0) begin
          prefixGp[2*k] = gpJoin(bitGp[2*k], pairPrefix[k-1]);
        end
      end
    end
  end

endmodule

// File: rtl/bk_sum_stage.sv
module bk_sum_stage
  import bk_adder_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  gpPair_t [WIDTH-1:0] bitGp,
  input  gpPair_t [WIDTH-1:0] prefixGp,
  input  logic                carryIn,
  output logic    [WIDTH-1:0] sum,
  output logic                carryOut
);

  logic [WIDTH:0] carryVec;
  gpPair_t        cinGrp;

  assign cinGrp.gen  = carryIn;
  assign cinGrp.prop = 1'b0;

  always_comb begin
    gpPair_t joined;
    carryVec[0] = carryIn;
    for (int i = 0; i < WIDTH; i++) begin
      joined        = gpJoin(prefixGp[i], cinGrp);
      carryVec[i+1] = joined.gen;
      sum[i]        = bitGp[i].prop ^ carryVec[i];
    end
  end

  assign carryOut = carryVec[WIDTH];

endmodule

// File: rtl/bk_prefix_adder.sv
module bk_prefix_adder
  import bk_adder_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             groupGen,
  output logic             groupProp
);

  localparam bit WIDTH_OK = (WIDTH >= 2) && ((WIDTH & (WIDTH - 1)) == 0);

  if (!WIDTH_OK) begin : gBadWidth
    $error("bk_prefix_adder: WIDTH must be a power of two of at least 2");
  end

  gpPair_t [WIDTH-1:0] bitGp;
  gpPair_t [WIDTH-1:0] prefixGp;

  bk_pg_gen #(.WIDTH(WIDTH)) uPg (
    .opA   (opA),
    .opB   (opB),
    .bitGp (bitGp)
  );

  bk_prefix_net #(.WIDTH(WIDTH)) uNet (
    .bitGp    (bitGp),
    .prefixGp (prefixGp)
  );

  bk_sum_stage #(.WIDTH(WIDTH)) uSum (
    .bitGp    (bitGp),
    .prefixGp (prefixGp),
    .carryIn  (carryIn),
    .sum      (sum),
    .carryOut (carryOut)
  );

  assign groupGen  = prefixGp[WIDTH-1].gen;
  assign groupProp = prefixGp[WIDTH-1].prop;

endmodule

// File: rtl/bk_prefix_adder_chk.sv
module bk_prefix_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [WIDTH-1:0] sum,
  input logic             carryOut,
  input logic             groupGen,
  input logic             groupProp
);

  logic [WIDTH:0] refFull;
  logic [WIDTH:0] refNoCin;

  assign refFull  = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
  assign refNoCin = {1'b0, opA} + {1'b0, opB};

  always_comb begin
    AST_SUM_VALUE: assert (sum == refFull[WIDTH-1:0]) else $error("sum mismatch"); // R1
    AST_CARRY_OUT: assert (carryOut == refFull[WIDTH]) else $error("carry mismatch"); // R2
    AST_WORD_PROP: assert (groupProp == (&(opA ^ opB))) else $error("group propagate mismatch"); // R3
    AST_WORD_GEN: assert (groupGen == refNoCin[WIDTH]) else $error("group generate mismatch"); // R4
    AST_COUT_SPLIT: assert (carryOut == (groupGen | (groupProp & carryIn))) else $error("carry split mismatch"); // R5
    AST_GP_EXCLUSIVE: assert (!(groupGen && groupProp)) else $error("group flags both set"); // R6
  end

endmodule

bind bk_prefix_adder bk_prefix_adder_chk #(.WIDTH(WIDTH)) i_chk (
  .opA       (opA),
  .opB       (opB),
  .carryIn   (carryIn),
  .sum       (sum),
  .carryOut  (carryOut),
  .groupGen  (groupGen),
  .groupProp (groupProp)
);

// File: tb/test_bk_prefix_adder.sv
`timescale 1ns/1ps
module test_bk_prefix_adder;

  localparam int W8  = 8;
  localparam int W32 = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  int checkCnt = 0;
  int failCnt  = 0;
  bit doneFlag = 1'b0;

  logic [W8-1:0]  a8, b8, s8;
  logic           ci8, co8, gg8, gp8;
  logic [W32-1:0] a32, b32, s32;
  logic           ci32, co32, gg32, gp32;

  bk_prefix_adder #(.WIDTH(W8)) i_bk_prefix_adder (
    .opA(a8), .opB(b8), .carryIn(ci8),
    .sum(s8), .carryOut(co8), .groupGen(gg8), .groupProp(gp8)
  );

  bk_prefix_adder #(.WIDTH(W32)) i_bk_prefix_adder_w32 (
    .opA(a32), .opB(b32), .carryIn(ci32),
    .sum(s32), .carryOut(co32), .groupGen(gg32), .groupProp(gp32)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check8();
    logic [W8:0] full, noCin;
    full  = {1'b0, a8} + {1'b0, b8} + {8'd0, ci8};
    noCin = {1'b0, a8} + {1'b0, b8};
    chk("R1 sum8", {56'd0, s8}, {56'd0, full[W8-1:0]});
    chk("R2 cout8", {63'd0, co8}, {63'd0, full[W8]});
    chk("R3 gprop8", {63'd0, gp8}, {63'd0, &(a8 ^ b8)});
    chk("R4 ggen8", {63'd0, gg8}, {63'd0, noCin[W8]});
    chk("R5 split8", {63'd0, co8}, {63'd0, noCin[W8] | ((&(a8 ^ b8)) & ci8)});
    chk("R6 excl8", {63'd0, gg8 & gp8}, 64'd0);
  endtask

  task automatic check32(input string tag);
    logic [W32:0] full, noCin;
    full  = {1'b0, a32} + {1'b0, b32} + {32'd0, ci32};
    noCin = {1'b0, a32} + {1'b0, b32};
    chk({"R7 R1 sum32 ", tag}, {32'd0, s32}, {32'd0, full[W32-1:0]});
    chk({"R7 R2 cout32 ", tag}, {63'd0, co32}, {63'd0, full[W32]});
    chk({"R7 R3 gprop32 ", tag}, {63'd0, gp32}, {63'd0, &(a32 ^ b32)});
    chk({"R7 R4 ggen32 ", tag}, {63'd0, gg32}, {63'd0, noCin[W32]});
  endtask

  task automatic apply8(input logic [W8-1:0] a, input logic [W8-1:0] b, input logic c);
    @(posedge clk);
    a8 = a; b8 = b; ci8 = c;
    @(negedge clk);
    check8();
  endtask

  task automatic apply32(input logic [W32-1:0] a, input logic [W32-1:0] b, input logic c,
                         input string tag);
    @(posedge clk);
    a32 = a; b32 = b; ci32 = c;
    @(negedge clk);
    check32(tag);
  endtask

  task automatic t_zero_state();
    apply8(8'd0, 8'd0, 1'b0);
    chk("R1 zero sum", {56'd0, s8}, 64'd0);
    chk("R6 zero flags", {62'd0, gg8, gp8}, 64'd0);
  endtask

  task automatic t_exhaustive8();
    for (int v = 0; v < (1 << 17); v++) begin
      apply8(v[7:0], v[15:8], v[16]);
    end
  endtask

  task automatic t_corners32();
    apply32('1, '0, 1'b1, "full ripple");
    chk("R7 ripple sum zero", {32'd0, s32}, 64'd0);
    chk("R7 ripple cout", {63'd0, co32}, 64'd1);
    chk("R5 ripple prop only", {62'd0, gg32, gp32}, 64'd1);
    apply32('1, '0, 1'b0, "prop no cin");
    chk("R5 no cin no carry", {63'd0, co32}, 64'd0);
    apply32('1, '1, 1'b1, "all ones");
    apply32(32'h8000_0000, 32'h8000_0000, 1'b0, "top gen");
    apply32(32'h5555_5555, 32'hAAAA_AAAA, 1'b0, "alternating");
  endtask

  task automatic t_random32();
    for (int n = 0; n < 10000; n++) begin
      apply32($urandom, $urandom, 1'($urandom), "random");
    end
  endtask

  initial begin
    a8 = '0; b8 = '0; ci8 = 1'b0;
    a32 = '0; b32 = '0; ci32 = 1'b0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    t_zero_state();
    t_corners32();
    t_exhaustive8();
    t_random32();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1'b1;
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule